// File: doc/BRIEF.md
# DMA Task Interrupt Aggregator

The block collects completion events from a set of DMA tasks (sixteen by default) into one pending register. A companion mask register can disable each task. Any task that is pending and enabled raises a single combined request. The parent interrupt controller treats that request as source 0 of its peripheral group.

When the parent services that source, the block also supplies a two-level vector for the task to service. The low field holds the index of the lowest-numbered task that is pending and enabled. The high field holds group code 3, the DMA task group. The parent's other groups use code 0 for critical, 1 for main and 2 for peripheral. Software acknowledges a task by writing a 1 to its pending bit.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset every pending bit is 0 and every mask bit is 1, so `req_o`, `vec_valid_o` and `vec_o` are all 0.
- R2: A 1 on `task_evt_i[n]` in a cycle sets bit n of `pend_o` from the next cycle on.
- R3: A write with `wr_en_i`=1 and `wr_sel_i`=0 clears each pending bit whose `wr_data_i` bit is 1. Pending bits whose data bit is 0 keep their value.
- R4: A write with `wr_en_i`=1 and `wr_sel_i`=1 loads `wr_data_i` into the mask register, visible on `mask_o` the next cycle. Bit n=1 disables task n.
- R5: `req_o` is 1 exactly when some task has its pending bit 1 and its mask bit 0. A task that is pending but masked does not raise it.
- R6: If an event and a write-1 clear hit the same pending bit in one cycle, the bit ends up set.
- R7: While `req_o` is 1, `vec_o[5:0]` is the index of the lowest-numbered task that is pending and unmasked.
- R8: While `req_o` is 1, `vec_o[7:6]` is 3 and `vec_valid_o` is 1. While `req_o` is 0, `vec_valid_o` and `vec_o` are 0.
- R9: Mask writes leave the pending bits alone. A task that became pending while masked raises `req_o` as soon as it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| task_evt_i | input | NUM_TASKS | Per-task completion event, one bit per task |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 pending (write-1-clear), 1 mask |
| wr_data_i | input | NUM_TASKS | Write data |
| pend_o | output | NUM_TASKS | Pending register |
| mask_o | output | NUM_TASKS | Mask register (1 disables) |
| req_o | output | 1 | Combined request to the parent's peripheral source 0 |
| vec_valid_o | output | 1 | Vector output is meaningful |
| vec_o | output | 8 | Two-level vector: group in [7:6], task index in [5:0] |

## Verification
The assertions check on every cycle that the pending bits follow events and write-1 clears, and that bits neither written nor hit by an event hold their value. They also check that mask writes land, and that any vector presented names an enabled pending task with no enabled pending task below it, under group code 3. The bench scenarios alone show the reset values, the collision rule and the later effect of unmasking a task that was latched while masked. They also show, through a long mixed stimulus sequence, that the request and vector match a reference model of the requirements.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned GRP_W = 2;
  localparam int unsigned IDX_W = 6;
  localparam int unsigned VEC_W = GRP_W + IDX_W;

  typedef enum logic [GRP_W-1:0] {
    GRP_CRIT   = 2'd0,
    GRP_MAIN   = 2'd1,
    GRP_PERIPH = 2'd2,
    GRP_DMA    = 2'd3
  } grp_e;

  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_MASK = 1'b1
  } wr_sel_e;

  function automatic logic [VEC_W-1:0] make_vec(grp_e grp, logic [IDX_W-1:0] idx);
    return {grp, idx};
  endfunction
endpackage

// File: rtl/dma_irq_pend.sv
module dma_irq_pend #(
  parameter int unsigned NUM_TASKS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_TASKS-1:0] set_i,
  input  logic [NUM_TASKS-1:0] clr_i,
  output logic [NUM_TASKS-1:0] pend_o
);
  for (genvar g = 0; g < NUM_TASKS; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_o[g] <= 1'b0;
      else if (set_i[g])  pend_o[g] <= 1'b1;  // event wins over clear
      else if (clr_i[g])  pend_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_irq_mask.sv
module dma_irq_mask #(
  parameter int unsigned NUM_TASKS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [NUM_TASKS-1:0] data_i,
  output logic [NUM_TASKS-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_o <= '1;
    else if (load_i) mask_o <= data_i;
  end
endmodule

// File: rtl/dma_irq_ffs.sv
module dma_irq_ffs #(
  parameter int unsigned NUM_TASKS = 16,
  parameter int unsigned IDX_W     = 6
) (
  input  logic [NUM_TASKS-1:0] vec_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_TASKS - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_TASKS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_TASKS-1:0] task_evt_i,
  input  logic                 wr_en_i,
  input  logic                 wr_sel_i,
  input  logic [NUM_TASKS-1:0] wr_data_i,
  output logic [NUM_TASKS-1:0] pend_o,
  output logic [NUM_TASKS-1:0] mask_o,
  output logic                 req_o,
  output logic                 vec_valid_o,
  output logic [7:0]           vec_o
);
  logic [NUM_TASKS-1:0] clr;
  logic [NUM_TASKS-1:0] active;
  logic                 any;
  logic [IDX_W-1:0]     idx;
  wr_sel_e              sel;

  assign sel = wr_sel_e'(wr_sel_i);
  assign clr = (wr_en_i && sel == SEL_PEND) ? wr_data_i : '0;

  dma_irq_pend #(.NUM_TASKS(NUM_TASKS)) i_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (task_evt_i),
    .clr_i (clr),
    .pend_o(pend_o)
  );

  dma_irq_mask #(.NUM_TASKS(NUM_TASKS)) i_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wr_en_i && sel == SEL_MASK),
    .data_i(wr_data_i),
    .mask_o(mask_o)
  );

  assign active = pend_o & ~mask_o;

  dma_irq_ffs #(.NUM_TASKS(NUM_TASKS), .IDX_W(IDX_W)) i_ffs (
    .vec_i(active),
    .any_o(any),
    .idx_o(idx)
  );

  assign req_o       = any;
  assign vec_valid_o = any;
  assign vec_o       = any ? make_vec(GRP_DMA, idx) : '0;
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk #(
  parameter int unsigned NUM_TASKS = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_TASKS-1:0] task_evt_i,
  input logic                 wr_en_i,
  input logic                 wr_sel_i,
  input logic [NUM_TASKS-1:0] wr_data_i,
  input logic [NUM_TASKS-1:0] pend_o,
  input logic [NUM_TASKS-1:0] mask_o,
  input logic                 req_o,
  input logic                 vec_valid_o,
  input logic [7:0]           vec_o
);
  logic [NUM_TASKS-1:0] clr_req, act, below;
  assign clr_req = (wr_en_i && !wr_sel_i) ? wr_data_i : '0;
  assign act     = pend_o & ~mask_o;
  always_comb begin
    for (int i = 0; i < NUM_TASKS; i++) below[i] = (i < int'(vec_o[5:0]));
  end

  p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & $past(task_evt_i)) == $past(task_evt_i)));

  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & $past(clr_req & ~task_evt_i)) == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((pend_o ^ $past(pend_o)) & ~$past(clr_req | task_evt_i)) == '0));

  p_mask_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> (mask_o == $past(wr_data_i)));

  p_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o == (act != '0));

  p_lowest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (act[vec_o[5:0]] && ((act & below) == '0)));

  p_group_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (vec_valid_o && vec_o[7:6] == 2'd3));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (!vec_valid_o && vec_o == '0));
endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NUM_TASKS(NUM_TASKS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .task_evt_i (task_evt_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .pend_o     (pend_o),
  .mask_o     (mask_o),
  .req_o      (req_o),
  .vec_valid_o(vec_valid_o),
  .vec_o      (vec_o)
);

// File: tb/test_dma_irq_agg.sv
`timescale 1ns/1ps
module test_dma_irq_agg;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic         we = 1'b0;
  logic         sel = 1'b0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] pend, mask;
  logic         req, vvalid;
  logic [7:0]   vec;

  logic [N-1:0] m_pend, m_mask;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dma_irq_agg #(.NUM_TASKS(N)) i_dma_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .task_evt_i(evt), .wr_en_i(we),
    .wr_sel_i(sel), .wr_data_i(wdata), .pend_o(pend), .mask_o(mask),
    .req_o(req), .vec_valid_o(vvalid), .vec_o(vec)
  );

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
    end
  endtask

  // drive one cycle, update the model, sample after the edge
  task automatic step(logic [N-1:0] e, logic w, logic s, logic [N-1:0] d);
    @(negedge clk);
    evt = e; we = w; sel = s; wdata = d;
    @(posedge clk);
    if (w && !s) m_pend = m_pend & ~d;
    if (w && s)  m_mask = d;
    m_pend = m_pend | e;
    #1;
    evt = '0; we = 1'b0; sel = 1'b0; wdata = '0;
  endtask

  task automatic chk_all(string r);
    logic [N-1:0] a;
    logic [7:0]   ev;
    a  = m_pend & ~m_mask;
    ev = 8'h00;
    for (int i = N - 1; i >= 0; i--) if (a[i]) ev = 8'hC0 | 8'(i);
    chk({r, " pend"}, 32'(pend), 32'(m_pend));
    chk({r, " mask"}, 32'(mask), 32'(m_mask));
    chk({r, " req"}, 32'(req), 32'(a != '0));
    chk({r, " valid"}, 32'(vvalid), 32'(a != '0));
    chk({r, " vec"}, 32'(vec), 32'(ev));
  endtask

  task automatic t_reset;
    m_pend = '0; m_mask = '1;
    #1;
    chk("R1 pend", 32'(pend), 32'h0);
    chk("R1 mask", 32'(mask), 32'hFFFF);
    chk("R1 req", 32'(req), 32'h0);
    chk("R1 vec", 32'(vec), 32'h0);
  endtask

  task automatic t_set_mask;
    step(16'h0100, 1'b0, 1'b0, '0);
    chk("R2 pend bit 8", 32'(pend), 32'h0100);
    chk("R5 masked no req", 32'(req), 32'h0);
    step('0, 1'b1, 1'b1, 16'hFEFF);
    chk("R4 mask load", 32'(mask), 32'hFEFF);
    chk("R9 unmask raises req", 32'(req), 32'h1);
    chk("R8 vec task 8", 32'(vec), 32'hC8);
    chk_all("R9");
  endtask

  task automatic t_w1c;
    step(16'h8421, 1'b0, 1'b0, '0);
    step('0, 1'b1, 1'b1, 16'h0000);
    chk_all("R7 multi");
    chk("R7 lowest is 0", 32'(vec), 32'hC0);
    step('0, 1'b1, 1'b0, 16'h0001);
    chk("R3 clear bit 0", 32'(pend), 32'h8520);
    chk("R7 next lowest 5", 32'(vec), 32'hC5);
    step('0, 1'b1, 1'b0, 16'h0000);
    chk("R3 zero write no effect", 32'(pend), 32'h8520);
    step('0, 1'b1, 1'b0, 16'hFFFF);
    chk("R3 clear all", 32'(pend), 32'h0);
    chk("R8 idle vec", 32'(vec), 32'h0);
    chk("R8 idle valid", 32'(vvalid), 32'h0);
  endtask

  task automatic t_collision;
    step(16'h0010, 1'b0, 1'b0, '0);
    step(16'h0010, 1'b1, 1'b0, 16'h0011);
    chk("R6 event beats clear", 32'(pend), 32'h0010);
    chk_all("R6");
  endtask

  task automatic t_mixed;
    logic [15:0] lfsr = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      logic [N-1:0] e;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      e = (lfsr[3:0] == 0) ? 16'h0 : (16'h1 << lfsr[7:4]) | (lfsr[0] ? 16'h8000 : 16'h0);
      step(e, lfsr[9] | lfsr[11], lfsr[12] & lfsr[1], {lfsr[6:0], lfsr[15:7]});
      chk_all("R5 R7 mixed");
    end
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_set_mask;
    t_w1c;
    t_collision;
    t_mixed;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule